// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with independent transmit and receive paths. Each path is paced by its own enable tick that runs at sixteen times the bit rate; the tick generators sit outside the block. A write on the data port queues one character for transmission. The receive path watches the serial line for a falling edge, decides every bit by a three-sample majority vote, and delivers the character into a one-entry holding register.

Two frame lengths are supported. An 8-bit frame has a start bit, eight data bits sent low bit first, and a stop bit. A 9-bit frame places one extra programmable bit between the data and the stop bit. In 9-bit mode an address-filter option lets a listening node accept only frames whose extra bit is 1, so data aimed at other nodes never raises its interrupt. The holding register is separate from the receive shifter, so a new character can begin arriving while the previous one is still unread. Both completion flags are sticky and stay set until software clears them; their OR forms the interrupt request.

Top module: `uart_mm`

## Requirements
- R1: After reset `txd` is 1, `tx_done`, `rx_done`, `irq` and `rx_bit9` are 0, and `rd_data` is 0.
- R2: With `mode9`=0 a write while the transmitter is idle sends a start bit 0, then `wr_data` bit 0 first through bit 7, then a stop bit 1. Each bit lasts 16 `tx_tick`s, and the start bit appears in the cycle after the first `tx_tick` that follows the write cycle.
- R3: With `mode9`=1 (sampled at the write) the ninth transmitted bit is the value of `tx_bit9` at the write, followed by the stop bit.
- R4: `tx_done` rises in the same cycle as the stop bit appears on `txd`. A write while a frame is waiting or being sent is ignored.
- R5: While `rx_en`=1 a 1-to-0 step seen on an `rx_tick` starts reception, and each bit is the majority of the samples at ticks 7, 8 and 9 of its 16. With `mode9`=0 the byte goes to `rd_data`, the stop bit goes to `rx_bit9`, and `rx_done` rises.
- R6: With `mode9`=1 the received ninth bit, not the stop bit, goes to `rx_bit9`.
- R7: With `mode9`=1 and `mp_en`=1 a frame whose ninth bit is 0 leaves `rx_done`, `rd_data` and `rx_bit9` unchanged. A frame whose ninth bit is 1 is accepted.
- R8: A frame that completes while `rx_done` is 1 is discarded, and `rd_data` keeps the earlier byte.
- R9: A frame that begins while `rx_done` is 1 is still received, and it is loaded if `rx_done` has been cleared before it completes.
- R10: A start bit whose vote reads 1 returns the receiver to idle without loading anything, and a later valid frame is still received.
- R11: `irq` is the OR of `tx_done` and `rx_done`. Each flag stays set until a pulse on its clear input (`clr_tx_done`, `clr_rx_done`). When a set and a clear fall in the same cycle, the set wins.
- R12: While `rx_en`=0 no reception starts, and a frame on `rxd` leaves `rx_done` and `rd_data` unchanged.
- R13: A single wrong sample among ticks 7, 8 and 9 of a bit does not change the received value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_tick | input | 1 | Transmit enable, 16 per bit |
| rx_tick | input | 1 | Receive enable, 16 per bit |
| mode9 | input | 1 | 1 selects 9-bit frames |
| rx_en | input | 1 | Allows new receptions to start |
| mp_en | input | 1 | Address filter in 9-bit mode |
| tx_bit9 | input | 1 | Ninth bit for transmitted frames |
| wr_en | input | 1 | Write strobe for transmit data |
| wr_data | input | 8 | Character to transmit |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rd_data | output | 8 | Last accepted received byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the accepted frame |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong sample phase in the transmitter appears on `txd` at the very next bit boundary, at most 16 ticks late. A reference model compares the line on every clock, so such a fault is seen within one bit time. A receiver fault, such as a misplaced vote window, a wrong bit index or a lost buffer qualifier, shows only when a frame completes. There it appears as a wrong `rd_data` or `rx_bit9`, or as `rx_done` rising when it should not, or failing to rise when it should. For that reason the receive stimulus includes back-to-back frames, filtered frames, a false start and a glitched sample, each of which pushes a different internal state out to the ports at frame end.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

  typedef enum logic [1:0] {
    TXS_IDLE,
    TXS_WAIT,
    TXS_SEND
  } tx_state_t;

  typedef enum logic {
    RXS_IDLE,
    RXS_RUN
  } rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_mm_sync.sv
module uart_mm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_mm_tx.sv
module uart_mm_tx
  import uart_mm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode9,
  input  logic              bit9_in,
  input  logic              clr_done,
  output logic              txd,
  output logic              done
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_DLAST = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] STOP_8    = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] STOP_9    = IDX_W'(DATA_W + 2);

  tx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shr;
  logic              b9_q;
  logic              m9_q;
  logic              txd_q;
  logic              done_q;

  logic [IDX_W-1:0]  stop_idx;
  logic [IDX_W-1:0]  nxt;

  assign stop_idx = m9_q ? STOP_9 : STOP_8;
  assign nxt      = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TXS_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shr    <= '0;
      b9_q   <= 1'b0;
      m9_q   <= 1'b0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (clr_done) done_q <= 1'b0;
      unique case (state)
        TXS_IDLE: begin
          if (wr_en) begin
            shr   <= wr_data;
            b9_q  <= bit9_in;
            m9_q  <= mode9;
            state <= TXS_WAIT;
          end
        end
        TXS_WAIT: begin
          if (tick) begin
            state <= TXS_SEND;
            cnt   <= '0;
            idx   <= '0;
            txd_q <= 1'b0;
          end
        end
        TXS_SEND: begin
          if (tick) begin
            if (cnt == CNT_LAST) begin
              cnt <= '0;
              if (idx == stop_idx) begin
                state <= TXS_IDLE;
              end else begin
                idx <= nxt;
                if (nxt == stop_idx) begin
                  txd_q  <= 1'b1;
                  done_q <= 1'b1;
                end else if (nxt <= IDX_DLAST) begin
                  txd_q <= shr[0];
                  shr   <= {1'b0, shr[DATA_W-1:1]};
                end else begin
                  txd_q <= b9_q;
                end
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= TXS_IDLE;
      endcase
    end
  end

  assign txd  = txd_q;
  assign done = done_q;

endmodule

// File: rtl/uart_mm_rx.sv
module uart_mm_rx
  import uart_mm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_in,
  input  logic              rx_en,
  input  logic              mode9,
  input  logic              mp_en,
  input  logic              clr_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bit9,
  output logic              done
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] VOTE_A    = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] VOTE_B    = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] VOTE_C    = CNT_W'(OVS / 2 + 1);
  localparam logic [IDX_W-1:0] IDX_DLAST = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] LAST_8    = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_9    = IDX_W'(DATA_W + 2);

  rx_state_t         state;
  logic              prev;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              smp_a;
  logic              smp_b;
  logic [DATA_W-1:0] shr;
  logic              ninth_q;
  logic [DATA_W-1:0] data_q;
  logic              b9_q;
  logic              done_q;

  logic              bit_now;
  logic [IDX_W-1:0]  last_idx;
  logic              ninth_fin;
  logic              accept;

  assign bit_now   = vote3(smp_a, smp_b, rx_in);
  assign last_idx  = mode9 ? LAST_9 : LAST_8;
  assign ninth_fin = mode9 ? ninth_q : bit_now;
  assign accept    = !done_q && !(mode9 && mp_en && !ninth_fin);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RXS_IDLE;
      prev    <= 1'b1;
      cnt     <= '0;
      idx     <= '0;
      smp_a   <= 1'b0;
      smp_b   <= 1'b0;
      shr     <= '0;
      ninth_q <= 1'b0;
      data_q  <= '0;
      b9_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (clr_done) done_q <= 1'b0;
      if (tick) begin
        prev <= rx_in;
        unique case (state)
          RXS_IDLE: begin
            if (rx_en && prev && !rx_in) begin
              state <= RXS_RUN;
              cnt   <= CNT_W'(1);
              idx   <= '0;
            end
          end
          RXS_RUN: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) idx <= idx + 1'b1;
            if (cnt == VOTE_A) smp_a <= rx_in;
            if (cnt == VOTE_B) smp_b <= rx_in;
            if (cnt == VOTE_C) begin
              if (idx == '0) begin
                if (bit_now) state <= RXS_IDLE;
              end else if (idx == last_idx) begin
                state <= RXS_IDLE;
                if (accept) begin
                  data_q <= shr;
                  b9_q   <= ninth_fin;
                  done_q <= 1'b1;
                end
              end else if (idx <= IDX_DLAST) begin
                shr <= {bit_now, shr[DATA_W-1:1]};
              end else begin
                ninth_q <= bit_now;
              end
            end
          end
          default: state <= RXS_IDLE;
        endcase
      end
    end
  end

  assign rd_data = data_q;
  assign bit9    = b9_q;
  assign done    = done_q;

endmodule

// File: rtl/uart_mm.sv
module uart_mm #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_tick,
  input  logic              rx_tick,
  input  logic              mode9,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic              tx_bit9,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_tx_done,
  input  logic              clr_rx_done,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_bit9,
  output logic              tx_done,
  output logic              rx_done,
  output logic              irq
);

  logic rx_sync;

  uart_mm_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (rxd),
    .q  (rx_sync)
  );

  uart_mm_tx #(
    .DATA_W(DATA_W),
    .OVS   (OVS)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .tick    (tx_tick),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mode9   (mode9),
    .bit9_in (tx_bit9),
    .clr_done(clr_tx_done),
    .txd     (txd),
    .done    (tx_done)
  );

  uart_mm_rx #(
    .DATA_W(DATA_W),
    .OVS   (OVS)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .tick    (rx_tick),
    .rx_in   (rx_sync),
    .rx_en   (rx_en),
    .mode9   (mode9),
    .mp_en   (mp_en),
    .clr_done(clr_rx_done),
    .rd_data (rd_data),
    .bit9    (rx_bit9),
    .done    (rx_done)
  );

  assign irq = tx_done | rx_done;

endmodule

// File: rtl/uart_mm_chk.sv
module uart_mm_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_tick,
  input logic              rx_tick,
  input logic              mode9,
  input logic              mp_en,
  input logic              clr_tx_done,
  input logic              clr_rx_done,
  input logic              txd,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_bit9,
  input logic              tx_done,
  input logic              rx_done
);

  assert_txd_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(tx_tick));

  assert_done_with_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> txd);

  assert_txdone_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !clr_tx_done) |=> tx_done);

  assert_rxdone_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !clr_rx_done) |=> rx_done);

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable({rd_data, rx_bit9}) |-> $rose(rx_done));

  assert_rxdone_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(rx_tick));

  assert_addr_filter_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_done) && $past(mode9 && mp_en)) |-> rx_bit9);

endmodule

bind uart_mm uart_mm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_tick    (tx_tick),
  .rx_tick    (rx_tick),
  .mode9      (mode9),
  .mp_en      (mp_en),
  .clr_tx_done(clr_tx_done),
  .clr_rx_done(clr_rx_done),
  .txd        (txd),
  .rd_data    (rd_data),
  .rx_bit9    (rx_bit9),
  .tx_done    (tx_done),
  .rx_done    (rx_done)
);

// File: tb/tb_uart_mm.sv
`timescale 1ns/1ps
module tb_uart_mm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_tick = 1'b0, rx_tick = 1'b0;
  logic       mode9 = 1'b0, rx_en = 1'b1, mp_en = 1'b0, tx_bit9 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_tx_done = 1'b0, clr_rx_done = 1'b0;
  logic       loop_en = 1'b1, rx_drv = 1'b1;
  logic       txd, rx_bit9, tx_done, rx_done, irq;
  logic [7:0] rd_data;
  wire        rxd = loop_en ? txd : rx_drv;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_mm dut (
    .clk(clk), .rst(rst), .tx_tick(tx_tick), .rx_tick(rx_tick),
    .mode9(mode9), .rx_en(rx_en), .mp_en(mp_en), .tx_bit9(tx_bit9),
    .wr_en(wr_en), .wr_data(wr_data), .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done), .rxd(rxd), .txd(txd), .rd_data(rd_data),
    .rx_bit9(rx_bit9), .tx_done(tx_done), .rx_done(rx_done), .irq(irq)
  );

  // tick pattern: one transmit and one receive tick every four clocks
  int ph = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    tx_tick <= (ph == 0);
    rx_tick <= (ph == 2);
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int   m_tx_st, m_tx_ticks, m_tx_len;
  bit   m_frame[0:11];
  logic m_txd, m_txdone;
  logic m_s1, m_s2, m_prev;
  int   m_rx_run, m_rx_ticks;
  logic m_v7, m_v8, m_nin;
  logic [7:0] m_shift, m_rd;
  logic m_b9, m_rxdone;
  int   st0, bpos, phs, lastb;
  logic v, old_done, fin9;

  function automatic logic maj(logic a, logic b, logic c);
    return (a && b) || (a && c) || (b && c);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tx_st = 0; m_tx_ticks = 0; m_tx_len = 10; m_txd = 1; m_txdone = 0;
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_rx_run = 0; m_rx_ticks = 0;
      m_v7 = 0; m_v8 = 0; m_nin = 0; m_shift = 0; m_rd = 0; m_b9 = 0; m_rxdone = 0;
    end else begin
      st0 = m_tx_st;
      if (clr_tx_done) m_txdone = 0;
      if (st0 == 2 && tx_tick) begin
        m_tx_ticks++;
        if (m_tx_ticks == 16 * m_tx_len) m_tx_st = 0;
        else if (m_tx_ticks % 16 == 0) begin
          bpos = m_tx_ticks / 16;
          m_txd = m_frame[bpos];
          if (bpos == m_tx_len - 1) m_txdone = 1;
        end
      end
      if (st0 == 1 && tx_tick) begin
        m_tx_st = 2; m_tx_ticks = 0; m_txd = 0;
      end
      if (st0 == 0 && wr_en) begin
        m_tx_st = 1;
        m_tx_len = mode9 ? 11 : 10;
        m_frame[0] = 0;
        for (int i = 0; i < 8; i++) m_frame[i+1] = wr_data[i];
        m_frame[9] = mode9 ? tx_bit9 : 1'b1;
        m_frame[10] = 1;
      end

      old_done = m_rxdone;
      if (clr_rx_done) m_rxdone = 0;
      if (rx_tick) begin
        if (m_rx_run == 0) begin
          if (rx_en && m_prev && !m_s2) begin m_rx_run = 1; m_rx_ticks = 0; end
        end else begin
          m_rx_ticks++;
          phs = m_rx_ticks % 16;
          bpos = m_rx_ticks / 16;
          if (phs == 7) m_v7 = m_s2;
          if (phs == 8) m_v8 = m_s2;
          if (phs == 9) begin
            v = maj(m_v7, m_v8, m_s2);
            lastb = mode9 ? 10 : 9;
            if (bpos == 0) begin
              if (v) m_rx_run = 0;
            end else if (bpos == lastb) begin
              m_rx_run = 0;
              fin9 = mode9 ? m_nin : v;
              if (!old_done && !(mode9 && mp_en && !fin9)) begin
                m_rd = m_shift; m_b9 = fin9; m_rxdone = 1;
              end
            end else if (bpos <= 8) m_shift[bpos-1] = v;
            else m_nin = v;
          end
        end
        m_prev = m_s2;
      end
      m_s2 = m_s1;
      m_s1 = rxd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2", "txd", txd, m_txd);
      check("R4", "tx_done", tx_done, m_txdone);
      check("R5", "rx_done", rx_done, m_rxdone);
      check("R5", "rd_data", rd_data, m_rd);
      check("R6", "rx_bit9", rx_bit9, m_b9);
      check("R11", "irq", irq, m_txdone | m_rxdone);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_write(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clr_rx();
    @(negedge clk); clr_rx_done = 1;
    @(negedge clk); clr_rx_done = 0;
  endtask

  task automatic clr_tx();
    @(negedge clk); clr_tx_done = 1;
    @(negedge clk); clr_tx_done = 0;
  endtask

  task automatic wait_tx();
    while (!tx_done) @(negedge clk);
    repeat (200) @(negedge clk);
  endtask

  // drives one 8-bit frame on rx_drv; glitch_pos >= 0 flips a short window in that bit
  task automatic send_rx(logic [7:0] d, int glitch_pos);
    logic [9:0] fr;
    fr = {1'b1, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        rx_drv = (b == glitch_pos && c >= 32 && c < 36) ? ~fr[b] : fr[b];
      end
    end
    @(negedge clk); rx_drv = 1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", "reset txd", txd, 1);
    check("R1", "reset tx_done", tx_done, 0);
    check("R1", "reset rx_done", rx_done, 0);
    check("R1", "reset irq", irq, 0);
    check("R1", "reset rd_data", rd_data, 0);
    check("R1", "reset rx_bit9", rx_bit9, 0);

    // R2/R4/R5: 8-bit loopback frame, second write during the frame is ignored
    do_write(8'hA5);
    repeat (100) @(negedge clk);
    do_write(8'h3C);
    wait_tx();
    check("R2", "loop byte", rd_data, 8'hA5);
    check("R5", "rx_done set", rx_done, 1);
    check("R5", "stop to rx_bit9", rx_bit9, 1);
    check("R4", "tx_done set", tx_done, 1);
    repeat (300) @(negedge clk);
    check("R11", "tx_done held", tx_done, 1);
    check("R11", "rx_done held", rx_done, 1);
    clr_rx();
    check("R11", "irq from tx only", irq, 1);
    clr_tx();
    check("R11", "irq cleared", irq, 0);
    repeat (900) @(negedge clk);
    check("R4", "ignored write sent nothing", tx_done, 0);
    check("R4", "ignored write received nothing", rx_done, 0);

    // R3/R6: 9-bit frames
    mode9 = 1; tx_bit9 = 1;
    do_write(8'h5A); wait_tx();
    check("R3", "9-bit byte", rd_data, 8'h5A);
    check("R6", "ninth bit 1", rx_bit9, 1);
    clr_rx(); clr_tx();
    tx_bit9 = 0;
    do_write(8'hC6); wait_tx();
    check("R3", "9-bit byte b", rd_data, 8'hC6);
    check("R6", "ninth bit 0", rx_bit9, 0);
    clr_rx(); clr_tx();

    // R7: address filter
    mp_en = 1;
    do_write(8'h77); wait_tx();
    check("R7", "data frame filtered", rx_done, 0);
    check("R7", "rd_data kept", rd_data, 8'hC6);
    clr_tx();
    tx_bit9 = 1;
    do_write(8'h81); wait_tx();
    check("R7", "address frame accepted", rx_done, 1);
    check("R7", "address byte", rd_data, 8'h81);
    clr_rx(); clr_tx();

    // external line, 8-bit
    loop_en = 0; mode9 = 0; mp_en = 0; tx_bit9 = 0;
    repeat (40) @(negedge clk);
    send_rx(8'h12, -1);
    send_rx(8'h34, -1);
    check("R8", "overrun keeps first", rd_data, 8'h12);
    check("R8", "flag still set", rx_done, 1);
    clr_rx();
    send_rx(8'h9C, -1);
    check("R5", "external byte", rd_data, 8'h9C);
    fork
      send_rx(8'hE1, -1);
      begin repeat (200) @(negedge clk); clr_rx(); end
    join
    check("R9", "buffered second byte", rd_data, 8'hE1);
    check("R9", "flag for second byte", rx_done, 1);
    clr_rx();

    // R10: false start
    @(negedge clk); rx_drv = 0;
    repeat (8) @(negedge clk); rx_drv = 1;
    repeat (300) @(negedge clk);
    check("R10", "false start no load", rx_done, 0);
    check("R10", "false start data kept", rd_data, 8'hE1);
    send_rx(8'h5E, -1);
    check("R10", "recovered after false start", rd_data, 8'h5E);
    clr_rx();

    // R12: receiver disabled
    rx_en = 0;
    send_rx(8'h42, -1);
    check("R12", "disabled no flag", rx_done, 0);
    check("R12", "disabled data kept", rd_data, 8'h5E);
    rx_en = 1;
    repeat (20) @(negedge clk);

    // R13: one corrupted sample inside data bit 3
    send_rx(8'hC3, 4);
    check("R13", "glitch voted out", rd_data, 8'hC3);
    send_rx(8'h00, -1);
    clr_rx();
    send_rx(8'h3C, 6);
    check("R13", "glitch voted out b", rd_data, 8'h3C);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule